// File: doc/BRIEF.md
# Per-Channel Spectral Equalizer and 4-Bit Requantizer

This block sits between a polyphase filter bank and the packet-building logic of a spectrometer or correlator front end. Each clock it can accept one complex frequency-domain sample for every parallel input lane. Each part of a sample is an 18-bit signed value. The block multiplies each part by a gain that is chosen by lane and by frequency channel. This flattens the passband while full precision is still held. Each product is then rounded and clipped to a signed 4-bit value, and the real and imaginary nibbles of each lane are packed into one byte.

A channel counter follows the position in the spectrum. It advances on every accepted sample, and an input sync marks channel 0. Host software loads gains through a simple write port. A new gain never takes effect partway through a spectrum. Valid and sync travel beside the data, so they leave the block aligned with the bytes they describe.

Top module: `spec_eq_requant`

## Requirements
- R1: While reset is high and after it is released, out_valid, out_sync and out_data are 0. Every gain resets to the unity value 4096.
- R2: Lane l of in_data occupies bits [36l+35:36l]. The real part is in the upper 18 bits and the imaginary part is in the lower 18 bits, both two's complement.
- R3: A sample with in_valid high and in_sync high is channel 0. Each further valid sample without sync takes the next channel, and the count wraps from CHANNELS-1 back to 0. Cycles with in_valid low do not move the count, and their data has no effect on any output.
- R4: Each lane has its own unsigned 16-bit gain for each channel, with 12 fraction bits (4096 means 1.0). A host write sets the gain selected by wr_lane and wr_chan to wr_coef.
- R5: For each part x with gain g, the output value is (x*g)/2^26 rounded to the nearest integer, with ties rounded away from zero.
- R6: A rounded result above +7 gives +7, and one below -7 gives -7. The code -8 is never produced.
- R7: In output byte l, located at out_data[8l+7:8l], the real nibble is in bits [7:4] and the imaginary nibble is in bits [3:0].
- R8: A gain write takes effect from the next valid sync sample. A write made in the same cycle as a sync sample takes effect from the sync after that. A wrap of the count without a sync does not apply pending writes.
- R9: Latency is exactly 3 cycles. out_valid and out_sync repeat in_valid and in_sync 3 cycles later, alongside the matching data. out_sync is never high without out_valid.
- R10: A write to one lane leaves the gains of every other lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input samples valid this cycle |
| in_sync | input | 1 | Marks channel 0 of a spectrum (sampled with in_valid) |
| in_data | input | LANES*36 (72) | Complex samples, one 36-bit word per lane |
| wr_en | input | 1 | Gain write strobe |
| wr_lane | input | LANE_W (1) | Lane selected by the write |
| wr_chan | input | CH_W (10) | Channel selected by the write |
| wr_coef | input | COEF_W (16) | Unsigned gain value |
| out_valid | output | 1 | Output bytes valid |
| out_sync | output | 1 | Output is channel 0 of a spectrum |
| out_data | output | LANES*8 (16) | Packed 4+4-bit complex bytes, one per lane |

## Verification
Two events can land in the same cycle: a gain write and the sync sample that commits earlier writes. The bench provokes this by asserting wr_en in the cycle that carries in_sync. It then checks that the byte for that channel keeps the old gain for the whole spectrum that begins there and switches only at the following sync. A second collision is also provoked: the channel count wraps while writes are still pending but no sync arrives. The outputs after the wrap must still use the old gains.

// File: rtl/eqq_pkg.sv
package eqq_pkg;

    localparam int SAMP_W = 18;

    typedef logic signed [SAMP_W-1:0] samp_t;

    typedef struct packed {
        samp_t re;
        samp_t im;
    } cplx_t;

    typedef struct packed {
        logic signed [3:0] re;
        logic signed [3:0] im;
    } nib_t;

    // Round half away from zero after dropping sh bits, then clip to +/-7.
    function automatic logic signed [3:0] requant4(input logic signed [63:0] p,
                                                   input int unsigned sh);
        logic [63:0] mag;
        logic [63:0] r;
        mag = p[63] ? 64'(-p) : 64'(p);
        r = (mag + (64'd1 << (sh - 1))) >> sh;
        if (r > 64'd7) r = 64'd7;
        return p[63] ? 4'(4'd0 - r[3:0]) : 4'(r[3:0]);
    endfunction

endpackage

// File: rtl/eqq_chan_ctr.sv
module eqq_chan_ctr #(
    parameter int CHANNELS = 1024,
    localparam int CH_W = $clog2(CHANNELS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_sync,
    output logic [CH_W-1:0] chan
);

    logic [CH_W-1:0] cnt_q;

    // A sync sample is channel 0 regardless of the running count.
    assign chan = in_sync ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= (chan == CH_W'(CHANNELS - 1)) ? '0 : chan + 1'b1;
        end
    end

    p_sync_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sync) |=> (cnt_q == CH_W'(1 % CHANNELS)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cnt_q));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sync && cnt_q == CH_W'(CHANNELS - 1)) |=> (cnt_q == '0));

endmodule

// File: rtl/eqq_coef_bank.sv
module eqq_coef_bank #(
    parameter int CHANNELS = 1024,
    parameter int COEF_W   = 16,
    parameter int DEF_COEF = 4096,
    localparam int CH_W = $clog2(CHANNELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic              commit,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [COEF_W-1:0] wr_data,
    output logic [COEF_W-1:0] rd_coef
);

    // live_q holds the newest value; held_q keeps the value that is in force
    // for the running spectrum while dirty_q marks an entry as changed.
    logic [COEF_W-1:0] live_q [CHANNELS];
    logic [COEF_W-1:0] held_q [CHANNELS];
    logic [CHANNELS-1:0] dirty_q;
    logic chk_armed;

    assign rd_coef = (dirty_q[rd_chan] && !commit) ? held_q[rd_chan] : live_q[rd_chan];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CHANNELS; i++) begin
                live_q[i] <= COEF_W'(DEF_COEF);
                held_q[i] <= COEF_W'(DEF_COEF);
            end
            dirty_q <= '0;
        end else begin
            if (commit) dirty_q <= '0;
            if (wr_en) begin
                live_q[wr_chan] <= wr_data;
                if (!dirty_q[wr_chan] || commit) held_q[wr_chan] <= live_q[wr_chan];
                dirty_q[wr_chan] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chk_armed <= 1'b0;
        else     chk_armed <= 1'b1;
    end

    // A write outside a commit cycle must not change what the same channel reads.
    p_defer_r8: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        ($past(wr_en && !commit && wr_chan == rd_chan) && !commit
         && rd_chan == $past(rd_chan)) |-> (rd_coef == $past(rd_coef)));

endmodule

// File: rtl/eqq_lane_dp.sv
module eqq_lane_dp
    import eqq_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int QSHIFT = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  cplx_t             samp,
    input  logic [COEF_W-1:0] coef,
    output nib_t              q
);

    localparam int PW = SAMP_W + COEF_W + 1;
    localparam longint SAT_LIM = longint'(15) <<< (QSHIFT - 1);

    cplx_t              s1_samp;
    logic [COEF_W-1:0]  s1_coef;
    logic signed [PW-1:0] p_re;
    logic signed [PW-1:0] p_im;
    logic signed [PW-1:0] gain_s;

    assign gain_s = $signed(PW'({1'b0, s1_coef}));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_samp <= '0;
            s1_coef <= '0;
            p_re    <= '0;
            p_im    <= '0;
            q       <= '0;
        end else begin
            s1_samp <= samp;
            s1_coef <= coef;
            p_re    <= PW'(s1_samp.re) * gain_s;
            p_im    <= PW'(s1_samp.im) * gain_s;
            q.re    <= requant4(64'(p_re), QSHIFT);
            q.im    <= requant4(64'(p_im), QSHIFT);
        end
    end

    p_sym_range_r6: assert property (@(posedge clk) disable iff (rst)
        (q.re != 4'sb1000) && (q.im != 4'sb1000));

    p_sat_pos_r6: assert property (@(posedge clk) disable iff (rst)
        (64'(p_re) >= SAT_LIM) |=> (q.re == 4'sd7));

    p_sat_neg_r6: assert property (@(posedge clk) disable iff (rst)
        (64'(p_im) <= -SAT_LIM) |=> (q.im == -4'sd7));

    p_zero_gain_r5: assert property (@(posedge clk) disable iff (rst)
        (s1_coef == '0) |=> ##1 (q == '0));

endmodule

// File: rtl/spec_eq_requant.sv
module spec_eq_requant
    import eqq_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int CHANNELS = 1024,
    parameter int COEF_W   = 16,
    parameter int QSHIFT   = 26,
    parameter int DEF_COEF = 4096,
    localparam int CH_W   = $clog2(CHANNELS),
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_sync,
    input  logic [LANES*36-1:0]   in_data,
    input  logic                  wr_en,
    input  logic [LANE_W-1:0]     wr_lane,
    input  logic [CH_W-1:0]       wr_chan,
    input  logic [COEF_W-1:0]     wr_coef,
    output logic                  out_valid,
    output logic                  out_sync,
    output logic [LANES*8-1:0]    out_data
);

    logic [CH_W-1:0] chan;
    logic            commit;
    logic [2:0]      v_pipe;
    logic [2:0]      s_pipe;

    assign commit = in_valid && in_sync;

    eqq_chan_ctr #(.CHANNELS(CHANNELS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .chan     (chan)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [COEF_W-1:0] coef;
        nib_t              q;
        logic              wr_hit;

        assign wr_hit = wr_en && (wr_lane == LANE_W'(l));

        eqq_coef_bank #(
            .CHANNELS (CHANNELS),
            .COEF_W   (COEF_W),
            .DEF_COEF (DEF_COEF)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .rd_chan (chan),
            .commit  (commit),
            .wr_en   (wr_hit),
            .wr_chan (wr_chan),
            .wr_data (wr_coef),
            .rd_coef (coef)
        );

        eqq_lane_dp #(.COEF_W(COEF_W), .QSHIFT(QSHIFT)) u_dp (
            .clk  (clk),
            .rst  (rst),
            .samp (cplx_t'(in_data[36*l +: 36])),
            .coef (coef),
            .q    (q)
        );

        assign out_data[8*l +: 8] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_pipe <= '0;
            s_pipe <= '0;
        end else begin
            v_pipe <= {v_pipe[1:0], in_valid};
            s_pipe <= {s_pipe[1:0], commit};
        end
    end

    assign out_valid = v_pipe[2];
    assign out_sync  = s_pipe[2];

    p_sync_has_valid_r9: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_valid);

    p_valid_latency_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##2 out_valid);

    p_idle_latency_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##2 !out_valid);

endmodule

// File: tb/spec_eq_requant_test.sv
module spec_eq_requant_test;

    localparam int LANES = 2;
    localparam int CH    = 1024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_sync = 1'b0;
    logic [LANES*36-1:0] in_data = '0;
    logic              wr_en = 1'b0;
    logic [0:0]        wr_lane = '0;
    logic [9:0]        wr_chan = '0;
    logic [15:0]       wr_coef = '0;
    logic              out_valid;
    logic              out_sync;
    logic [LANES*8-1:0] out_data;

    spec_eq_requant uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
        .in_data(in_data), .wr_en(wr_en), .wr_lane(wr_lane), .wr_chan(wr_chan),
        .wr_coef(wr_coef), .out_valid(out_valid), .out_sync(out_sync),
        .out_data(out_data)
    );

    always #5ns clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit [31:0] lf = 32'h1ACE_B00C;

    int cur_g [LANES][CH];
    int nxt_g [LANES][CH];
    int mchan = 0;

    logic [LANES*8-1:0] exp_d [$];
    bit                 exp_s [$];
    int                 exp_c [$];
    string              exp_t [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int spec_val(int k);
        case (k % 12)
            0: return 0;        1: return 8192;     2: return 8191;
            3: return -8192;    4: return -8191;    5: return 24576;
            6: return -24576;   7: return 131071;   8: return -131072;
            9: return 114688;   10: return 122879;  default: return 122880;
        endcase
    endfunction

    function automatic logic [3:0] model_q(int x, int g);
        longint p, mag, r;
        p = longint'(x) * longint'(g);
        mag = (p < 0) ? -p : p;
        r = (mag + (longint'(1) <<< 25)) >>> 26;
        if (r > 7) r = 7;
        return (p < 0) ? 4'(-r) : 4'(r);
    endfunction

    function automatic void lf_step();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endfunction

    task automatic step(input bit v, input bit s, input bit we, input int wl,
                        input int wc, input int wd, input string tag);
        logic [LANES*8-1:0] e;
        @(negedge clk);
        in_valid = v;
        in_sync  = s;
        wr_en    = we;
        wr_lane  = 1'(wl);
        wr_chan  = 10'(wc);
        wr_coef  = 16'(wd);
        if (v) begin
            if (s) begin
                mchan = 0;
                for (int l = 0; l < LANES; l++)
                    for (int c = 0; c < CH; c++) cur_g[l][c] = nxt_g[l][c];
            end
            for (int l = 0; l < LANES; l++) begin
                int re, im;
                if (mchan < 12) begin
                    re = spec_val(mchan + l);
                    im = spec_val(mchan + 6 + l);
                end else begin
                    lf_step(); re = int'($signed(lf[17:0]));
                    lf_step(); im = int'($signed(lf[17:0]));
                end
                in_data[36*l +: 36] = {18'(re), 18'(im)};
                e[8*l +: 8] = {model_q(re, cur_g[l][mchan]), model_q(im, cur_g[l][mchan])};
            end
            exp_d.push_back(e);
            exp_s.push_back(s);
            exp_c.push_back(cyc);
            exp_t.push_back(tag);
            mchan = (mchan + 1) % CH;
        end else begin
            lf_step();
            in_data = {lf[7:0], lf, lf};  // R3: data of idle cycles must not appear
        end
        if (we) nxt_g[wl][wc] = wd;
    endtask

    task automatic run(input int n, input bit first_sync, input string tag);
        for (int i = 0; i < n; i++) begin
            if (i % 9 == 8) step(0, 0, 0, 0, 0, 0, tag);
            step(1, first_sync && i == 0, 0, 0, 0, 0, tag);
        end
    endtask

    task automatic wr(input int l, input int c, input int d);
        step(0, 0, 1, l, c, d, "R4 write");
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                checks++;
                if (exp_d.size() == 0) begin
                    fails++;
                    $display("FAIL R9: out_valid with nothing expected, got %h expected none", out_data);
                end else begin
                    logic [LANES*8-1:0] ed; bit es; int ec; string et;
                    ed = exp_d.pop_front(); es = exp_s.pop_front();
                    ec = exp_c.pop_front(); et = exp_t.pop_front();
                    if (out_data !== ed || out_sync !== es || cyc != ec + 3) begin
                        fails++;
                        $display("FAIL %s R7 R9: cycle %0d data %h sync %0b, expected %h sync %0b at cycle %0d",
                                 et, cyc, out_data, out_sync, ed, es, ec + 3);
                    end
                end
            end else if (exp_c.size() > 0 && cyc > exp_c[0] + 3) begin
                checks++; fails++;
                $display("FAIL R9: output missing at cycle %0d, got valid 0 expected %h",
                         cyc, exp_d[0]);
                void'(exp_d.pop_front()); void'(exp_s.pop_front());
                void'(exp_c.pop_front()); void'(exp_t.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 10ns);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < LANES; l++)
            for (int c = 0; c < CH; c++) begin cur_g[l][c] = 4096; nxt_g[l][c] = 4096; end
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sync !== 1'b0 || out_data !== '0) begin
            fails++;
            $display("FAIL R1: in reset got %b/%b/%h expected 0/0/0", out_valid, out_sync, out_data);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sync !== 1'b0 || out_data !== '0) begin
            fails++;
            $display("FAIL R1: after reset got %b/%b/%h expected 0/0/0", out_valid, out_sync, out_data);
        end

        // Spectrum A: default gains, rounding ties, saturation, idle gaps; writes stay pending
        run(100, 1, "R1 R2 R3 R5 R6 R7 default gain");
        wr(0, 5, 8192);
        wr(1, 7, 2048);
        wr(0, 9, 65535);
        wr(0, 8, 0);
        run(924, 0, "R8 pending writes not yet applied");

        // Spectrum B: commit plus a write in the same cycle as the sync sample
        step(1, 1, 1, 1, 2, 16384, "R4 R8 R10 write on sync cycle");
        run(1023, 0, "R4 R6 R10 new gains per lane");

        // Spectrum C: cut short by an early sync
        run(150, 1, "R3 R8 same-cycle write now applied");

        // Spectrum D: pending write, then wrap without sync
        run(50, 1, "R3 early sync restarts at channel 0");
        wr(0, 3, 0);
        run(974, 0, "R5 R8 full spectrum");
        run(20, 0, "R3 R8 wrap without sync keeps old gains");

        // Spectrum E: sync applies the pending write
        run(16, 1, "R8 R5 commit after wrap");

        repeat (8) step(0, 0, 0, 0, 0, 0, "drain");
        checks++;
        if (exp_d.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d outputs never produced, expected 0 outstanding", exp_d.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule